// File: doc/BRIEF.md
# Dual-Counter PWM Timer

This peripheral holds two identical reloadable counters behind a small word-addressed register bus. Each counter has a control register, a load register and a read-only count register. A counter counts up or down from its load value. When it rolls over it shows the wrapped value for one clock, raises a one-clock generate pulse and, if auto-reload is set, takes the load value again. A counting cycle therefore lasts the load value plus 2 clocks when counting down, and (MAX − load) plus 2 clocks when counting up, with MAX = 2^CNT_W − 1.

When both control registers are set up for pulse-width mode, the two counters drive a single output pin. Counter 0 sets the period and counter 1 sets the high time. A rollover of counter 0 drives the pin high and restarts counter 1 from its load value. A rollover of counter 1 drives the pin low. Software loads both counters, then writes the start-all bit so that both begin counting in the same clock. Load values written while a counter runs take effect at its next reload.

Each counter is a four-state machine. The states are STOP (idle or held in forced load), COUNT (stepping), WRAP (the rollover clock, with the pulse asserted) and HOLD (stopped after a rollover without auto-reload). The transitions are:
- `go`: STOP→COUNT, or COUNT→COUNT when the terminal value has not been reached.
- `roll`: STOP/COUNT→WRAP when the count is at its terminal value.
- `reload`: WRAP→COUNT when auto-reload is set.
- `park`: WRAP→HOLD when auto-reload is clear.
- `halt`: any state→STOP when the run bit is clear or forced load is set.
- `restart`: any running state→COUNT with the load value, taken by counter 1 on each period rollover.

Top module: `dual_pwm_timer`

## Requirements
- R1: After reset every register reads 0 and `pwm_o`, `gen0_o` and `gen1_o` are low.
- R2: While the forced-load bit (control bit 4) is set, the count register equals the load register from the next clock on, and the counter does not step.
- R3: With run (bit 5) and down (bit 0) set, a cycle lasts load+2 clocks. The rollover clock shows MAX in the count register and raises a one-clock generate pulse.
- R4: With run set and down clear, a cycle lasts MAX−load+2 clocks.
- R5: With auto-reload (bit 3) clear, the counter rolls over once, gives one pulse, then holds the wrapped value. With auto-reload set, it reloads on every rollover.
- R6: A load value written while a counter runs does not change the current cycle. It sets the length of the cycles after the next reload.
- R7: A control write with the start-all bit (bit 6) set sets the run bit of both counters on the same edge, so both begin stepping in the same clock.
- R8: Writing 0 to a control register freezes that counter's count from the next clock.
- R9: `gen0_o`/`gen1_o` carry the rollover pulse only while generate-out enable (bit 2) is set.
- R10: In pulse-width mode the output period equals counter 0's cycle length P, and the high time equals counter 1's cycle length D, starting at each period rollover, for 2 ≤ D < P.
- R11: When D ≥ P, the output stays low for the whole period.
- R12: Pulse-width mode requires, in both control registers, bits 7 (PWM enable), 2, 3 and 5 set and bits 4, 1 (capture mode) and 8 (cascade) clear. Otherwise `pwm_o` is low.
- R13: Word addresses: 0/1/2 are counter 0's control/load/count, and 4/5/6 are counter 1's control/load/count. Writes to count addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Word address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| gen0_o | output | 1 | Counter 0 rollover pulse |
| gen1_o | output | 1 | Counter 1 rollover pulse |
| pwm_o | output | 1 | Pulse-width output |

## Verification
The bench measures cycle lengths in both count directions, including the +2 clocks. A design missing the rollover clock would give periods one short. It checks that the start-all bit starts both counters together by reading their counts one clock apart; a skewed start shows up as a count off by one. It also checks that a load written mid-cycle waits for the reload, which an early-applying design would fail. The pulse-width cases cover D=P−1, D=P and D>P, plus each blocking control bit. A design that sets the pin on every period rollover would stay high when D ≥ P instead of low.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    typedef struct packed {
        logic cascade;      // bit 8
        logic pwm_en;       // bit 7
        logic start_all;    // bit 6
        logic run;          // bit 5
        logic force_load;   // bit 4
        logic auto_rl;      // bit 3
        logic gen_en;       // bit 2
        logic capt_mode;    // bit 1
        logic count_down;   // bit 0
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef enum logic [1:0] {
        CS_STOP  = 2'd0,
        CS_COUNT = 2'd1,
        CS_WRAP  = 2'd2,
        CS_HOLD  = 2'd3
    } cnt_state_e;

    function automatic logic pwm_ready(input ctl_t c);
        return c.pwm_en & c.gen_en & c.auto_rl & c.run &
               ~c.force_load & ~c.capt_mode & ~c.cascade;
    endfunction

endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             force_load,
    input  logic             count_down,
    input  logic             auto_rl,
    input  logic [CNT_W-1:0] load_val,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    cnt_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             active, at_term;

    assign active  = run & ~force_load;
    assign at_term = count_down ? (cnt_q == '0) : (cnt_q == MAXV);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_STOP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (force_load) begin
            state_n = CS_STOP;
            cnt_n   = load_val;
        end else if (!active) begin
            state_n = CS_STOP;
        end else if (restart) begin
            state_n = CS_COUNT;
            cnt_n   = load_val;
        end else begin
            unique case (state_q)
                CS_STOP, CS_COUNT: begin
                    if (at_term) begin
                        state_n = CS_WRAP;
                        cnt_n   = count_down ? MAXV : '0;
                    end else begin
                        state_n = CS_COUNT;
                        cnt_n   = count_down ? cnt_q - 1'b1 : cnt_q + 1'b1;
                    end
                end
                CS_WRAP: begin
                    if (auto_rl) begin
                        state_n = CS_COUNT;
                        cnt_n   = load_val;
                    end else begin
                        state_n = CS_HOLD;
                    end
                end
                CS_HOLD: state_n = CS_HOLD;
                default: state_n = CS_STOP;
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = (state_q == CS_WRAP);

    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> !wrap_o);
    p_load_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        force_load |=> cnt_o == $past(load_val));
    p_frozen_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !force_load) |=> $stable(cnt_o));
    p_hold_parked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_HOLD && active) |=> $stable(cnt_o));

endmodule

// File: rtl/pwmt_regfile.sv
module pwmt_regfile
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [31:0]      bus_wdata,
    input  logic [CNT_W-1:0] cnt0,
    input  logic [CNT_W-1:0] cnt1,
    output ctl_t             ctl0,
    output ctl_t             ctl1,
    output logic [CNT_W-1:0] ld0,
    output logic [CNT_W-1:0] ld1,
    output logic [31:0]      bus_rdata
);
    localparam logic [1:0] SLOT_CTL = 2'd0;
    localparam logic [1:0] SLOT_LD  = 2'd1;
    localparam logic [1:0] SLOT_CNT = 2'd2;

    ctl_t wr_ctl;
    logic wr_ctl_any, wr_all;
    logic unused_bits;

    assign wr_ctl      = ctl_t'(bus_wdata[CTL_W-1:0]);
    assign wr_ctl_any  = bus_wr && (bus_addr[1:0] == SLOT_CTL);
    assign wr_all      = wr_ctl_any && wr_ctl.start_all;
    assign unused_bits = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl0 <= '0;
            ctl1 <= '0;
            ld0  <= '0;
            ld1  <= '0;
        end else begin
            if (wr_ctl_any && !bus_addr[2]) ctl0 <= wr_ctl;
            if (wr_ctl_any &&  bus_addr[2]) ctl1 <= wr_ctl;
            if (wr_all) begin
                ctl0.run <= 1'b1;
                ctl1.run <= 1'b1;
            end
            if (bus_wr && bus_addr == {1'b0, SLOT_LD}) ld0 <= bus_wdata[CNT_W-1:0];
            if (bus_wr && bus_addr == {1'b1, SLOT_LD}) ld1 <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            {1'b0, SLOT_CTL}: bus_rdata = 32'(ctl0);
            {1'b0, SLOT_LD }: bus_rdata = 32'(ld0);
            {1'b0, SLOT_CNT}: bus_rdata = 32'(cnt0);
            {1'b1, SLOT_CTL}: bus_rdata = 32'(ctl1);
            {1'b1, SLOT_LD }: bus_rdata = 32'(ld1);
            {1'b1, SLOT_CNT}: bus_rdata = 32'(cnt1);
            default:          bus_rdata = '0;
        endcase
    end

    p_start_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_all |=> (ctl0.run && ctl1.run));

endmodule

// File: rtl/pwmt_pwmgen.sv
module pwmt_pwmgen
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_t             ctl0,
    input  ctl_t             ctl1,
    input  logic [CNT_W-1:0] ld0,
    input  logic [CNT_W-1:0] ld1,
    input  logic             wrap0,
    input  logic             wrap1,
    output logic             restart1,
    output logic             pwm_o
);
    localparam int CW = CNT_W + 2;
    localparam logic [CNT_W-1:0] MAXV = '1;

    function automatic logic [CW-1:0] cycles_of(input logic down, input logic [CNT_W-1:0] l);
        if (down) return CW'(l) + CW'(2);
        return CW'(MAXV - l) + CW'(2);
    endfunction

    logic ok, duty_lt, pwm_q;

    assign ok       = pwm_ready(ctl0) & pwm_ready(ctl1);
    assign duty_lt  = cycles_of(ctl1.count_down, ld1) < cycles_of(ctl0.count_down, ld0);
    assign restart1 = ok & wrap0;

    always_ff @(posedge clk) begin
        if (!rst_n)                pwm_q <= 1'b0;
        else if (!ok)              pwm_q <= 1'b0;
        else if (wrap0 && duty_lt) pwm_q <= 1'b1;
        else if (wrap1)            pwm_q <= 1'b0;
    end

    assign pwm_o = pwm_q;

    p_off_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ok |=> !pwm_o);
    p_rise_on_period_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_o) |-> $past(wrap0));
    p_long_duty_no_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_o && !duty_lt) |=> !pwm_o);

endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        gen0_o,
    output logic        gen1_o,
    output logic        pwm_o
);
    generate
        if (CNT_W != 8 && CNT_W != 16 && CNT_W != 32) begin : g_bad_width
            $error("CNT_W must be 8, 16 or 32");
        end
    endgenerate

    ctl_t             ctl [2];
    logic [CNT_W-1:0] ld  [2];
    logic [CNT_W-1:0] cnt [2];
    logic [1:0]       wrap;
    logic [1:0]       restart;
    logic             restart1;

    pwmt_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .cnt0      (cnt[0]),
        .cnt1      (cnt[1]),
        .ctl0      (ctl[0]),
        .ctl1      (ctl[1]),
        .ld0       (ld[0]),
        .ld1       (ld[1]),
        .bus_rdata (bus_rdata)
    );

    assign restart = {restart1, 1'b0};

    for (genvar g = 0; g < 2; g++) begin : g_cnt
        pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (ctl[g].run),
            .force_load (ctl[g].force_load),
            .count_down (ctl[g].count_down),
            .auto_rl    (ctl[g].auto_rl),
            .load_val   (ld[g]),
            .restart    (restart[g]),
            .cnt_o      (cnt[g]),
            .wrap_o     (wrap[g])
        );
    end

    pwmt_pwmgen #(.CNT_W(CNT_W)) u_pwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl0     (ctl[0]),
        .ctl1     (ctl[1]),
        .ld0      (ld[0]),
        .ld1      (ld[1]),
        .wrap0    (wrap[0]),
        .wrap1    (wrap[1]),
        .restart1 (restart1),
        .pwm_o    (pwm_o)
    );

    assign gen0_o = wrap[0] & ctl[0].gen_en;
    assign gen1_o = wrap[1] & ctl[1].gen_en;

    p_gen_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[0].gen_en |-> !gen0_o);

endmodule

// File: tb/dual_pwm_timer_test.sv
module dual_pwm_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        gen0_o, gen1_o, pwm_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct { string req; int val; } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_pwm_timer #(.CNT_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gen0_o(gen0_o), .gen1_o(gen1_o), .pwm_o(pwm_o)
    );

    // driver side of the scoreboard
    task automatic sb_push(input string req, input int val);
        exp_t e;
        e.req = req;
        e.val = val;
        exp_q.push_back(e);
    endtask

    // monitor side: pop the oldest expectation and compare
    task automatic sb_got(input int got);
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (got != e.val) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", e.req, got, e.val);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic gen0_gap(output int g);
        while (!gen0_o) @(negedge clk);
        g = 0;
        do begin @(negedge clk); g++; end while (!gen0_o);
    endtask

    task automatic pwm_shape(output int hi, output int per);
        while (pwm_o) @(negedge clk);
        while (!pwm_o) @(negedge clk);
        hi = 0;
        while (pwm_o) begin hi++; @(negedge clk); end
        per = hi;
        while (!pwm_o) begin per++; @(negedge clk); end
    endtask

    task automatic count_window(input int n, output int pw, output int g0);
        pw = 0; g0 = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pw += int'(pwm_o);
            g0 += int'(gen0_o);
        end
    endtask

    task automatic pwm_setup(input int p, input int d);
        wr(3'd0, 0); wr(3'd4, 0);
        wr(3'd1, p - 2); wr(3'd5, d - 2);
        wr(3'd0, 32'h10); wr(3'd4, 32'h10);
        wr(3'd0, 32'h8D); wr(3'd4, 32'hED);
    endtask

    initial begin
        int v, v2, hi, per, pw, g0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R13: reset values at every mapped address
        sb_push("R1 ctl0", 0);   rd(3'd0, v); sb_got(v);
        sb_push("R1 load0", 0);  rd(3'd1, v); sb_got(v);
        sb_push("R1 count0", 0); rd(3'd2, v); sb_got(v);
        sb_push("R1 ctl1", 0);   rd(3'd4, v); sb_got(v);
        sb_push("R1 count1", 0); rd(3'd6, v); sb_got(v);
        sb_push("R1 pwm_o", 0);  sb_got(int'(pwm_o));

        // R2: forced load copies load into count
        wr(3'd1, 5); wr(3'd0, 32'h10);
        sb_push("R2 count0 after load", 5); rd(3'd2, v); sb_got(v);
        // R13: write to count address is ignored
        wr(3'd2, 77);
        sb_push("R13 count write ignored", 5); rd(3'd2, v); sb_got(v);

        // R3: down count, period L+2, one-clock pulse
        wr(3'd0, 32'h2D);
        gen0_gap(v); sb_push("R3 down period", 7); sb_got(v);
        @(negedge clk); sb_push("R3 pulse width", 0); sb_got(int'(gen0_o));

        // R6: load change mid-cycle applies at next reload
        wr(3'd1, 9);
        v = 0;
        while (!gen0_o) begin @(negedge clk); v++; end
        sb_push("R6 old cycle kept", 1); sb_got(int'(v <= 7));
        gen0_gap(v); sb_push("R6 new period", 11); sb_got(v);

        // R8: writing zero freezes the count
        wr(3'd0, 0);
        rd(3'd2, v); repeat (3) @(negedge clk); rd(3'd2, v2);
        sb_push("R8 frozen count", v); sb_got(v2);

        // R4: up count period MAX-L+2
        wr(3'd1, 252); wr(3'd0, 32'h10); wr(3'd0, 32'h2C);
        gen0_gap(v); sb_push("R4 up period", 5); sb_got(v);

        // R5: no auto-reload -> single pulse then hold at MAX
        wr(3'd0, 0); wr(3'd1, 3); wr(3'd0, 32'h10); wr(3'd0, 32'h25);
        count_window(40, pw, g0);
        sb_push("R5 single pulse", 1); sb_got(g0);
        sb_push("R3 R5 held wrap value", 255); rd(3'd2, v); sb_got(v);

        // R9: generate pulses suppressed when gen-enable clear
        wr(3'd0, 0); wr(3'd0, 32'h10); wr(3'd0, 32'h29);
        count_window(30, pw, g0);
        sb_push("R9 no gen pulse", 0); sb_got(g0);

        // R7: start-all starts both counters on the same edge
        wr(3'd0, 0); wr(3'd4, 0);
        wr(3'd1, 8); wr(3'd5, 2);
        wr(3'd0, 32'h10); wr(3'd4, 32'h10);
        wr(3'd0, 32'h8D); wr(3'd4, 32'hED);
        sb_push("R7 count0 one step", 7); rd(3'd2, v); sb_got(v);
        sb_push("R7 count1 two steps", 0); rd(3'd6, v); sb_got(v);
        sb_push("R7 ctl0 run set", 32'hAD); rd(3'd0, v); sb_got(v);

        // R10: P=10, D=4
        pwm_setup(10, 4);
        pwm_shape(hi, per);
        sb_push("R10 high time", 4); sb_got(hi);
        sb_push("R10 period", 10);   sb_got(per);

        // R10 boundary: D=P-1
        pwm_setup(7, 6);
        pwm_shape(hi, per);
        sb_push("R10 high P-1", 6); sb_got(hi);
        sb_push("R10 period 7", 7); sb_got(per);

        // R11: D = P and D > P stay low
        pwm_setup(8, 8);
        count_window(40, pw, g0);
        sb_push("R11 D=P low", 0); sb_got(pw);
        pwm_setup(8, 12);
        count_window(40, pw, g0);
        sb_push("R11 D>P low", 0); sb_got(pw);

        // R12: each blocking condition forces low
        pwm_setup(10, 4);
        count_window(25, pw, g0);
        sb_push("R12 running baseline", 1); sb_got(int'(pw > 0));
        wr(3'd0, 32'hAF);
        count_window(30, pw, g0);
        sb_push("R12 capture mode low", 0); sb_got(pw);
        pwm_setup(10, 4);
        wr(3'd0, 32'h1AD);
        count_window(30, pw, g0);
        sb_push("R12 cascade low", 0); sb_got(pw);
        pwm_setup(10, 4);
        wr(3'd0, 0);
        count_window(30, pw, g0);
        sb_push("R12 disabled low", 0); sb_got(pw);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule